// File: doc/BRIEF.md
# Burst-of-Four Quad-Data-Rate SRAM Core

This block is a cycle-accurate, synthesizable model of a synchronous static memory with independent read and write data paths, where every access moves a fixed burst of four words. It runs on a beat clock at twice the command rate, so one double-data-rate beat is one clock cycle and one command cycle is two clock cycles. A single address bus carries the read address on the first beat of each command cycle and the write address on the second.

After a write command, four data beats with their per-byte enables arrive on later clocks. A read command returns four words on later clocks, each marked by a valid flag. Write data passes through a one-word buffer before it reaches the array. A read fetch that hits the buffered word merges the buffered bytes over the array contents, so a read always sees every write that was commanded before it. A read and a write burst can be in flight at the same time. A request of either kind is accepted at most once per two command cycles.

Top module: `qb4_sram_core`

## Requirements
- R1: While rst_n is low, and until a read returns data, rvalid is 0 and rdata is all zeros.
- R2: Clock edges alternate between read slots and write slots. The first rising edge with rst_n high is a read slot. A read request is taken only on a read slot, and a write request only on a write slot. A request in the other slot is ignored and leaves the memory and the outputs unchanged.
- R3: Once a request is accepted, a request of the same kind one command cycle later (two edges later) is ignored. A request two command cycles later (four edges later) is accepted.
- R4: A read accepted at edge t with burst address A drives word A*4+n on rdata from edge t+5+n, for n = 0..3. The beats follow one another on consecutive edges.
- R5: rvalid is 1 in exactly the cycles that carry read beats. In every other cycle rvalid is 0 and rdata is all zeros.
- R6: A write accepted at edge t with burst address A takes wdata and wbe at edge t+2+n as the data for word A*4+n, for n = 0..3.
- R7: Bit b of wbe set to 1 writes byte b (wdata bits b*8+7 down to b*8) of that beat's word. A 0 leaves that byte unchanged.
- R8: A read returns the data of every write accepted before it, merged per byte. This includes a write accepted in the command cycle just before the read, whose last beat is still in the write buffer.
- R9: A write accepted after a read, including the write in the same command cycle as the read, does not change the data that read returns.
- R10: A read and a write accepted in the same command cycle, to different addresses, both complete with their normal timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock, twice the command rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, sampled on read slots |
| wr_req | input | 1 | Write request, sampled on write slots |
| addr | input | ADDR_W | Shared burst address: read address on read slots, write address on write slots |
| wdata | input | NB*BW | Write data beat |
| wbe | input | NB | Per-byte write enables for the current beat, 1 = write |
| rdata | output | NB*BW | Read data beat, zero when not valid |
| rvalid | output | 1 | High for each cycle that carries a read beat |

## Verification
On every cycle, the assertions check the following. Requests are accepted only in their own slot. Accepted requests of one kind are spaced at least one command cycle apart. Valid read beats come in runs that are multiples of four, and each run starts five edges after an acceptance. rdata is zero outside valid beats. An array commit always follows a captured write beat. Only the bench scenarios can show that the returned words are correct. These include byte-masked merges, a read placed right behind a write to the same burst, a write in the same command cycle as a read that must not leak into it, and requests that should be ignored, whose effect is checked by reading the burst back.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
   localparam int BURST_LEN      = 4;
   localparam int BEAT_W         = $clog2(BURST_LEN);
   // Registers between the array fetch and the rdata port.
   localparam int RD_TAIL_STAGES = 3;

   typedef enum logic {
      SLOT_READ  = 1'b0,
      SLOT_WRITE = 1'b1
   } slot_e;
endpackage

// File: rtl/qb4_burst_seq.sv
// Accepts one burst command and steps through its four beats.
// Beat n strobes on the edge two cycles after acceptance, plus n.
module qb4_burst_seq
   import qb4_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     slot_open,
   input  logic                     req,
   input  logic [ADDR_W-1:0]        base,
   output logic                     acc,
   output logic                     beat_en,
   output logic [ADDR_W+BEAT_W-1:0] word_addr
);
   logic              pend_q;
   logic              act_q;
   logic [BEAT_W-1:0] beat_q;
   logic [ADDR_W-1:0] pend_base_q;
   logic [ADDR_W-1:0] base_q;
   logic              busy;

   // The next command of this kind waits until half the burst is out.
   assign busy = pend_q || (act_q && (beat_q < BEAT_W'(BURST_LEN / 2)));
   assign acc  = slot_open && req && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_base_q <= '0;
      end else begin
         pend_q <= acc;
         if (acc) begin
            pend_base_q <= base;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         beat_q <= '0;
         base_q <= '0;
      end else if (pend_q) begin
         act_q  <= 1'b1;
         beat_q <= '0;
         base_q <= pend_base_q;
      end else if (act_q) begin
         beat_q <= beat_q + BEAT_W'(1);
         if (beat_q == BEAT_W'(BURST_LEN - 1)) begin
            act_q <= 1'b0;
         end
      end
   end

   assign beat_en   = act_q;
   assign word_addr = {base_q, beat_q};
endmodule

// File: rtl/qb4_store.sv
// Word array with a one-word write buffer and byte-merging read bypass.
module qb4_store
   import qb4_pkg::*;
#(
   parameter int WA_W = 8,
   parameter int NB   = 2,
   parameter int BW   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_en,
   input  logic [WA_W-1:0]    cap_addr,
   input  logic [NB*BW-1:0]   cap_data,
   input  logic [NB-1:0]      cap_be,
   input  logic               fetch_en,
   input  logic [WA_W-1:0]    fetch_addr,
   output logic               out_v,
   output logic [NB*BW-1:0]   out_d,
   output logic               commit_we
);
   localparam int DW    = NB * BW;
   localparam int WORDS = 1 << WA_W;

   logic [DW-1:0]   mem_q [WORDS];
   logic            wb_v_q;
   logic [WA_W-1:0] wb_a_q;
   logic [DW-1:0]   wb_d_q;
   logic [NB-1:0]   wb_be_q;
   logic [DW-1:0]   arr_word;
   logic [DW-1:0]   merged;
   logic            hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_v_q  <= 1'b0;
         wb_a_q  <= '0;
         wb_d_q  <= '0;
         wb_be_q <= '0;
      end else begin
         wb_v_q <= cap_en;
         if (cap_en) begin
            wb_a_q  <= cap_addr;
            wb_d_q  <= cap_data;
            wb_be_q <= cap_be;
         end
      end
   end

   // Commit the buffered beat one edge after capture.
   always_ff @(posedge clk) begin
      if (wb_v_q) begin
         for (int b = 0; b < NB; b++) begin
            if (wb_be_q[b]) begin
               mem_q[wb_a_q][b*BW +: BW] <= wb_d_q[b*BW +: BW];
            end
         end
      end
   end

   assign arr_word = mem_q[fetch_addr];
   assign hit      = wb_v_q && (wb_a_q == fetch_addr);

   for (genvar b = 0; b < NB; b++) begin : g_merge
      assign merged[b*BW +: BW] = (hit && wb_be_q[b]) ? wb_d_q[b*BW +: BW]
                                                       : arr_word[b*BW +: BW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_v <= 1'b0;
         out_d <= '0;
      end else begin
         out_v <= fetch_en;
         out_d <= fetch_en ? merged : '0;
      end
   end

   assign commit_we = wb_v_q;
endmodule

// File: rtl/qb4_tail.sv
// Fixed-depth delay from the fetch register to the output port.
module qb4_tail #(
   parameter int DW     = 16,
   parameter int STAGES = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  logic [DW-1:0] in_d,
   output logic          out_v,
   output logic [DW-1:0] out_d
);
   logic [STAGES-1:0] v_q;
   logic [DW-1:0]     d_q [STAGES];

   if (STAGES < 1) begin : g_bad_depth
      $error("qb4_tail: STAGES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
         for (int s = 0; s < STAGES; s++) begin
            d_q[s] <= '0;
         end
      end else begin
         v_q[0] <= in_v;
         d_q[0] <= in_d;
         for (int s = 1; s < STAGES; s++) begin
            v_q[s] <= v_q[s-1];
            d_q[s] <= d_q[s-1];
         end
      end
   end

   assign out_v = v_q[STAGES-1];
   assign out_d = d_q[STAGES-1];
endmodule

// File: rtl/qb4_sram_core.sv
module qb4_sram_core
   import qb4_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int NB     = 2,
   parameter int BW     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_req,
   input  logic               wr_req,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [NB*BW-1:0]   wdata,
   input  logic [NB-1:0]      wbe,
   output logic [NB*BW-1:0]   rdata,
   output logic               rvalid
);
   localparam int DW   = NB * BW;
   localparam int WA_W = ADDR_W + BEAT_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("qb4_sram_core: ADDR_W out of range 1..12");
   end
   if (NB < 1 || BW < 1) begin : g_bad_width
      $error("qb4_sram_core: NB and BW must be positive");
   end

   slot_e           ph_q;
   logic            rd_acc, wr_acc;
   logic            rd_beat, wr_beat;
   logic [WA_W-1:0] rd_word, wr_word;
   logic            f_v;
   logic [DW-1:0]   f_d;
   logic            commit_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= SLOT_READ;
      end else begin
         ph_q <= (ph_q == SLOT_READ) ? SLOT_WRITE : SLOT_READ;
      end
   end

   qb4_burst_seq #(.ADDR_W(ADDR_W)) i_rd_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_open (ph_q == SLOT_READ),
      .req       (rd_req),
      .base      (addr),
      .acc       (rd_acc),
      .beat_en   (rd_beat),
      .word_addr (rd_word)
   );

   qb4_burst_seq #(.ADDR_W(ADDR_W)) i_wr_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_open (ph_q == SLOT_WRITE),
      .req       (wr_req),
      .base      (addr),
      .acc       (wr_acc),
      .beat_en   (wr_beat),
      .word_addr (wr_word)
   );

   qb4_store #(.WA_W(WA_W), .NB(NB), .BW(BW)) i_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_en     (wr_beat),
      .cap_addr   (wr_word),
      .cap_data   (wdata),
      .cap_be     (wbe),
      .fetch_en   (rd_beat),
      .fetch_addr (rd_word),
      .out_v      (f_v),
      .out_d      (f_d),
      .commit_we  (commit_we)
   );

   qb4_tail #(.DW(DW), .STAGES(RD_TAIL_STAGES)) i_tail (
      .clk   (clk),
      .rst_n (rst_n),
      .in_v  (f_v),
      .in_d  (f_d),
      .out_v (rvalid),
      .out_d (rdata)
   );
endmodule

// File: rtl/qb4_chk.sv
module qb4_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_acc,
   input logic          wr_acc,
   input logic          rd_beat,
   input logic          wr_beat,
   input logic          commit_we,
   input logic          rvalid,
   input logic [DW-1:0] rdata
);
   logic       par_q;
   logic [1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= 1'b0;
         run_q <= 2'd0;
      end else begin
         par_q <= ~par_q;
         run_q <= rvalid ? run_q + 2'd1 : 2'd0;
      end
   end

   p_slot_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |-> (par_q == 1'b0));
   p_slot_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |-> (par_q == 1'b1));
   p_spacing_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |=> ##1 !rd_acc);
   p_spacing_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |=> ##1 !wr_acc);
   p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |=> ##5 rvalid);
   p_valid_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> $past(rd_beat, 4));
   p_burst_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rvalid) |-> (run_q == 2'd0));
   p_rdata_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid |-> (rdata == '0));
   p_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      commit_we |-> $past(wr_beat));
endmodule

bind qb4_sram_core qb4_chk #(.DW(NB*BW)) i_qb4_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_acc    (rd_acc),
   .wr_acc    (wr_acc),
   .rd_beat   (rd_beat),
   .wr_beat   (wr_beat),
   .commit_we (commit_we),
   .rvalid    (rvalid),
   .rdata     (rdata)
);

// File: tb/test_qb4_sram_core.sv
module test_qb4_sram_core;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 6;
   localparam int NB         = 2;
   localparam int BW         = 8;
   localparam int DW         = NB * BW;

   logic              clk    = 1'b0;
   logic              rst_n  = 1'b0;
   logic              rd_req = 1'b0;
   logic              wr_req = 1'b0;
   logic [ADDR_W-1:0] addr   = '0;
   logic [DW-1:0]     wdata  = '0;
   logic [NB-1:0]     wbe    = '0;
   logic [DW-1:0]     rdata;
   logic              rvalid;

   always #(CLK_PERIOD / 2) clk = ~clk;

   qb4_sram_core #(.ADDR_W(ADDR_W), .NB(NB), .BW(BW)) i_qb4_sram_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_req (rd_req),
      .wr_req (wr_req),
      .addr   (addr),
      .wdata  (wdata),
      .wbe    (wbe),
      .rdata  (rdata),
      .rvalid (rvalid)
   );

   int    n_chk   = 0;
   int    n_fail  = 0;
   string tag     = "R1";
   int    cyc     = 0;
   bit    m_ph    = 1'b0;
   int    last_rd = -100;
   int    last_wr = -100;
   bit    done    = 1'b0;

   logic [DW-1:0] ref_mem [int];
   int            fetch_at [int];
   int            cap_at [int];
   logic [DW-1:0] exp_d [int];
   logic [DW-1:0] plan_d [int];
   logic [NB-1:0] plan_be [int];

   task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at edge %0d: actual %h expected %h", rq, cyc, act, exp);
      end
   endtask

   // Behavioural reference: slot rules, spacing, beat schedules.
   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 1'b0;
         cyc  = 0;
      end else begin
         cyc = cyc + 1;
         if (fetch_at.exists(cyc)) begin
            exp_d[cyc + 3] = ref_mem.exists(fetch_at[cyc]) ? ref_mem[fetch_at[cyc]] : '0;
            fetch_at.delete(cyc);
         end
         if (cap_at.exists(cyc)) begin
            logic [DW-1:0] cur;
            cur = ref_mem.exists(cap_at[cyc]) ? ref_mem[cap_at[cyc]] : '0;
            for (int b = 0; b < NB; b++) begin
               if (wbe[b]) cur[b*BW +: BW] = wdata[b*BW +: BW];
            end
            ref_mem[cap_at[cyc]] = cur;
            cap_at.delete(cyc);
         end
         if (!m_ph && rd_req && (cyc - last_rd) > 2) begin
            last_rd = cyc;
            for (int n = 0; n < 4; n++) fetch_at[cyc + 2 + n] = int'(addr) * 4 + n;
         end
         if (m_ph && wr_req && (cyc - last_wr) > 2) begin
            last_wr = cyc;
            for (int n = 0; n < 4; n++) cap_at[cyc + 2 + n] = int'(addr) * 4 + n;
         end
         m_ph = !m_ph;
      end
   end

   // Compare outputs every cycle, away from the active edge.
   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            chk("R1 rvalid", {{(DW-1){1'b0}}, rvalid}, '0);
            chk("R1 rdata", rdata, '0);
         end else if (exp_d.exists(cyc)) begin
            chk({tag, "/R5 rvalid"}, {{(DW-1){1'b0}}, rvalid}, {{(DW-1){1'b0}}, 1'b1});
            chk({tag, " rdata"}, rdata, exp_d[cyc]);
            exp_d.delete(cyc);
         end else begin
            chk({tag, "/R5 rvalid"}, {{(DW-1){1'b0}}, rvalid}, '0);
            chk({tag, "/R5 rdata"}, rdata, '0);
         end
      end
   end

   // Write data driver: planned beats where due, junk elsewhere.
   always @(negedge clk) begin
      if (plan_d.exists(cyc + 1)) begin
         wdata = plan_d[cyc + 1];
         wbe   = plan_be[cyc + 1];
      end else begin
         wdata = DW'($urandom);
         wbe   = NB'($urandom);
      end
   end

   // One command cycle: read slot then write slot.
   task automatic cc(input bit do_rd, input int ra, input bit do_wr, input int wa,
                     input logic [DW-1:0] d0, input logic [4*NB-1:0] masks);
      if (m_ph) @(negedge clk);
      rd_req = do_rd;
      wr_req = 1'b0;
      addr   = ADDR_W'(ra);
      @(negedge clk);
      rd_req = 1'b0;
      wr_req = do_wr;
      addr   = ADDR_W'(wa);
      if (do_wr) begin
         for (int n = 0; n < 4; n++) begin
            plan_d[cyc + 3 + n]  = d0 ^ DW'(n * 16'h3c5a);
            plan_be[cyc + 3 + n] = masks[n*NB +: NB];
         end
      end
      @(negedge clk);
      wr_req = 1'b0;
   endtask

   // Requests placed in the wrong slots.
   task automatic wrong_slots(input int ra, input int wa);
      if (m_ph) @(negedge clk);
      wr_req = 1'b1;
      addr   = ADDR_W'(wa);
      @(negedge clk);
      wr_req = 1'b0;
      rd_req = 1'b1;
      addr   = ADDR_W'(ra);
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R6: fill every burst with full byte enables, back-to-back writes.
      tag = "R6";
      for (int a = 0; a < 64; a++) begin
         cc(1'b0, 0, 1'b1, a, DW'(a * 97 + 13), '1);
         cc(1'b0, 0, 1'b0, 0, '0, '0);
      end
      idle(8);

      // R4: back-to-back reads.
      tag = "R4";
      for (int a = 0; a < 12; a++) begin
         cc(1'b1, a * 5, 1'b0, 0, '0, '0);
         cc(1'b0, 0, 1'b0, 0, '0, '0);
      end
      idle(10);

      // R10: read and write in flight together.
      tag = "R10";
      for (int a = 0; a < 6; a++) begin
         cc(1'b1, a, 1'b1, a + 20, DW'(16'h7100 + a), '1);
         cc(1'b0, 0, 1'b0, 0, '0, '0);
      end
      cc(1'b1, 22, 1'b0, 0, '0, '0);
      idle(10);

      // R7: partial byte enables.
      tag = "R7";
      cc(1'b0, 0, 1'b1, 5, 16'ha5c3, 8'b10_01_00_11);
      idle(8);
      cc(1'b1, 5, 1'b0, 0, '0, '0);
      idle(10);

      // R8: read directly behind a masked write to the same burst.
      tag = "R8";
      cc(1'b0, 0, 1'b1, 7, 16'h5e21, 8'b01_10_11_01);
      cc(1'b1, 7, 1'b0, 0, '0, '0);
      idle(10);

      // R9: write in the same command cycle as the read must not leak.
      tag = "R9";
      cc(1'b1, 9, 1'b1, 9, 16'hc0de, 8'b11_10_01_11);
      cc(1'b0, 0, 1'b0, 0, '0, '0);
      tag = "R8";
      cc(1'b1, 9, 1'b0, 0, '0, '0);
      idle(10);

      // R3: second request one command cycle later is ignored.
      tag = "R3";
      cc(1'b1, 3, 1'b1, 30, 16'h1111, '1);
      cc(1'b1, 4, 1'b1, 31, 16'h2222, '1);
      cc(1'b0, 0, 1'b0, 0, '0, '0);
      idle(8);
      cc(1'b1, 31, 1'b0, 0, '0, '0);
      idle(10);

      // R2: requests in the wrong slot are ignored.
      tag = "R2";
      wrong_slots(12, 40);
      idle(8);
      cc(1'b1, 40, 1'b0, 0, '0, '0);
      idle(16);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule